// File: doc/BRIEF.md
# Coprocessor Operand-Transfer Primitive Checker

This block judges a coprocessor request to evaluate an effective address and move operand bytes. The request carries a 3-bit category code, a direction bit and a byte count. The block also takes the mode and register fields of the instruction's effective address. One cycle after a request it gives a verdict: proceed, abort (F-line emulation), or protocol violation. On proceed it also reports how far the scan program counter advances for the extension words that the address consumes.

After a proceed verdict the block lists the transfer sizes that carry the operand. It emits one size per cycle: as many 4-byte transfers as fit, then at most one 2-byte transfer, then at most one 1-byte transfer. A done flag marks the last entry of the list. While a list is being produced the block is busy and ignores new requests. The address arithmetic, the bus cycles and the exception handling belong to the surrounding logic.

Top module: `eaxfer_check`

## Requirements
- R1: The effective address is classified by mode (ea_mode, ea_reg):
  - 0 is data register direct: data and alterable.
  - 1 is address register direct: alterable only.
  - 2, 5 and 6, and 7 with register 0 or 1 (absolute short or long), count as control, data, memory and alterable.
  - 3 and 4 count as data, memory and alterable.
  - 7 with register 2 or 3 (PC-relative) counts as control, data and memory.
  - 7 with register 4 (immediate) counts as data and memory.
  - 7 with register 5 to 7 belongs to no category.

  valid_ea selects the required category:
  - 000 control and alterable
  - 001 data and alterable
  - 010 memory and alterable
  - 011 alterable
  - 100 control
  - 101 data
  - 110 memory
  - 111 any legal mode

  An address outside the required category gives verdict 01 (abort).
- R2: When the category matches, to_cop is 0 (write toward the address) and the address is not alterable, the verdict is 10 (protocol violation). This check ranks below R1.
- R3: For register direct modes (0 and 1), a length other than 1, 2 or 4 gives verdict 10.
- R4: For immediate, the length must be 1 or even, and to_cop must be 1. Otherwise the verdict is 10.
- R5: Memory modes accept any length from 0 to 255. A request that passes every check gives verdict 00 (proceed).
- R6: On proceed, scan_inc is twice the number of extension words:
  - 0 for modes 0 to 4
  - 1 for modes 5 and 6 and for mode 7 with register 0, 2 or 3
  - 2 for mode 7 with register 1
  - for immediate, 1 when the length is 2 or less, otherwise length/2
- R7: After proceed, xfer_vld pulses once per cycle starting two cycles after the accepted start. xfer_size gives the size in bytes: 4s first, then an optional 2, then an optional 1. xfer_done is high with the last transfer. A length of 0 gives a single xfer_done pulse two cycles after start, with xfer_vld low.
- R8: verdict_vld pulses for one cycle, one cycle after a start that was sampled while busy was low. busy stays high from then until the done cycle. A start seen while busy is high produces no verdict.
- R9: After reset, busy, verdict_vld, xfer_vld and xfer_done are low.
- R10: An abort or protocol-violation verdict produces no transfers and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe |
| valid_ea | input | 3 | Required address category |
| to_cop | input | 1 | 1: operand moves toward the coprocessor |
| op_len | input | LEN_W | Operand length in bytes |
| ea_mode | input | 3 | Effective address mode field |
| ea_reg | input | 3 | Effective address register field |
| busy | output | 1 | Transfer list in progress; start is ignored |
| verdict_vld | output | 1 | Verdict strobe |
| verdict | output | 2 | 00 proceed, 01 abort, 10 protocol violation |
| scan_inc | output | LEN_W | Scan PC increment in bytes (valid on proceed) |
| xfer_vld | output | 1 | A transfer size is presented |
| xfer_size | output | 3 | Transfer size in bytes: 1, 2 or 4 |
| xfer_done | output | 1 | Last entry of the transfer list |

## Verification
The verdict and scan increment are due exactly one cycle after the edge that accepts a start. The transfer list begins on the following cycle and advances one entry per cycle until done. The bench samples every output on the falling edge. It pops a verdict expectation whenever verdict_vld is high, and a transfer expectation whenever xfer_vld or xfer_done is high. Any output that appears early, late or without an expectation therefore meets an empty or mismatched queue. A start pulsed while the block is busy has no expectation pushed, so a stray verdict from it is reported.

// File: rtl/eaxfer_check.sv
module eaxfer_check #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       valid_ea,
  input  logic             to_cop,
  input  logic [LEN_W-1:0] op_len,
  input  logic [2:0]       ea_mode,
  input  logic [2:0]       ea_reg,
  output logic             busy,
  output logic             verdict_vld,
  output logic [1:0]       verdict,
  output logic [LEN_W-1:0] scan_inc,
  output logic             xfer_vld,
  output logic [2:0]       xfer_size,
  output logic             xfer_done
);

  localparam logic [1:0] V_OK = 2'b00, V_ABORT = 2'b01, V_PV = 2'b10;

  logic m7;
  logic is_dn, is_an, is_full, is_step, is_pcr, is_imm;
  assign m7      = ea_mode == 3'd7;
  assign is_dn   = ea_mode == 3'd0;
  assign is_an   = ea_mode == 3'd1;
  assign is_full = ea_mode == 3'd2 || ea_mode == 3'd5 || ea_mode == 3'd6 || (m7 && ea_reg <= 3'd1);
  assign is_step = ea_mode == 3'd3 || ea_mode == 3'd4;
  assign is_pcr  = m7 && (ea_reg == 3'd2 || ea_reg == 3'd3);
  assign is_imm  = m7 && ea_reg == 3'd4;

  logic k_data, k_mem, k_ctl, k_alt, k_any;
  assign k_data = is_dn | is_full | is_step | is_pcr | is_imm;
  assign k_mem  = is_full | is_step | is_pcr | is_imm;
  assign k_ctl  = is_full | is_pcr;
  assign k_alt  = is_dn | is_an | is_full | is_step;
  assign k_any  = k_alt | k_data;

  logic cat_ok;
  always_comb begin
    case (valid_ea)
      3'b000:  cat_ok = k_ctl & k_alt;
      3'b001:  cat_ok = k_data & k_alt;
      3'b010:  cat_ok = k_mem & k_alt;
      3'b011:  cat_ok = k_alt;
      3'b100:  cat_ok = k_ctl;
      3'b101:  cat_ok = k_data;
      3'b110:  cat_ok = k_mem;
      default: cat_ok = k_any;
    endcase
  end

  logic len_ok;
  always_comb begin
    if (is_dn || is_an)
      len_ok = op_len == LEN_W'(1) || op_len == LEN_W'(2) || op_len == LEN_W'(4);
    else if (is_imm)
      len_ok = (op_len == LEN_W'(1) || !op_len[0]) && to_cop;
    else
      len_ok = 1'b1;
  end

  logic [1:0] verdict_n;
  always_comb begin
    if (!cat_ok)                verdict_n = V_ABORT;
    else if (!to_cop && !k_alt) verdict_n = V_PV;
    else if (!len_ok)           verdict_n = V_PV;
    else                        verdict_n = V_OK;
  end

  logic [LEN_W-1:0] ext_words;
  always_comb begin
    ext_words = '0;
    if (ea_mode == 3'd5 || ea_mode == 3'd6) ext_words = LEN_W'(1);
    else if (m7) begin
      case (ea_reg)
        3'd0, 3'd2, 3'd3: ext_words = LEN_W'(1);
        3'd1:             ext_words = LEN_W'(2);
        3'd4:             ext_words = (op_len <= LEN_W'(2)) ? LEN_W'(1) : (op_len >> 1);
        default:          ext_words = '0;
      endcase
    end
  end

  logic             go;
  logic [LEN_W-1:0] rem;
  logic [2:0]       chunk;
  logic             accept;

  assign accept = start && !go;
  assign busy   = go;
  assign chunk  = (rem >= LEN_W'(4)) ? 3'd4 : (rem >= LEN_W'(2)) ? 3'd2 : (rem != '0) ? 3'd1 : 3'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go          <= 1'b0;
      rem         <= '0;
      verdict_vld <= 1'b0;
      verdict     <= V_OK;
      scan_inc    <= '0;
      xfer_vld    <= 1'b0;
      xfer_size   <= 3'd0;
      xfer_done   <= 1'b0;
    end else begin
      verdict_vld <= accept;
      xfer_vld    <= 1'b0;
      xfer_done   <= 1'b0;
      if (accept) begin
        verdict  <= verdict_n;
        scan_inc <= ext_words << 1;
        rem      <= op_len;
        go       <= verdict_n == V_OK;
      end else if (go) begin
        xfer_vld  <= chunk != 3'd0;
        xfer_size <= chunk;
        xfer_done <= rem == LEN_W'(chunk);
        rem       <= rem - LEN_W'(chunk);
        go        <= rem != LEN_W'(chunk);
      end
    end
  end

  a_r8_verdict_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |-> $past(start && !busy));
  a_r10_no_xfer_after_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && verdict != V_OK) |=> (!xfer_vld && !xfer_done));
  a_r7_legal_size: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_vld |-> (xfer_size == 3'd1 || xfer_size == 3'd2 || xfer_size == 3'd4));
  a_r7_two_then_one: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_vld && xfer_size == 3'd2 && !xfer_done) |=> (xfer_vld && xfer_size == 3'd1 && xfer_done));
  a_r8_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !busy);
  a_r5_proceed_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && verdict == V_OK) |-> busy);

endmodule

// File: tb/eaxfer_check_tb.sv
module eaxfer_check_tb;
  logic clk = 0, rst_n = 0, start = 0, to_cop = 0;
  logic [2:0] valid_ea = 0, ea_mode = 0, ea_reg = 0;
  logic [7:0] op_len = 0;
  logic busy, verdict_vld, xfer_vld, xfer_done;
  logic [1:0] verdict;
  logic [7:0] scan_inc;
  logic [2:0] xfer_size;

  eaxfer_check u_dut (.clk, .rst_n, .start, .valid_ea, .to_cop, .op_len, .ea_mode, .ea_reg,
    .busy, .verdict_vld, .verdict, .scan_inc, .xfer_vld, .xfer_size, .xfer_done);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [9:0] vq[$];
  logic [3:0] cq[$];
  string tagq[$];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic push_model(logic [2:0] c, logic d, logic [7:0] l, logic [2:0] m, logic [2:0] r, string tag);
    bit dat, mem, ctl, alt, ok;
    bit reg_dir, imm;
    logic [1:0] v;
    int w, left;
    reg_dir = m <= 1;
    imm = (m == 7 && r == 4);
    dat = (m == 0) || (m >= 2 && m <= 6) || (m == 7 && r <= 4);
    mem = (m >= 2 && m <= 6) || (m == 7 && r <= 4);
    ctl = m == 2 || m == 5 || m == 6 || (m == 7 && r <= 3);
    alt = m <= 6 || (m == 7 && r <= 1);
    case (c)
      0: ok = ctl && alt;  1: ok = dat && alt;  2: ok = mem && alt;  3: ok = alt;
      4: ok = ctl;  5: ok = dat;  6: ok = mem;  default: ok = alt || dat;
    endcase
    if (!ok) v = 2'b01;
    else if (!d && !alt) v = 2'b10;
    else if (reg_dir && !(l == 1 || l == 2 || l == 4)) v = 2'b10;
    else if (imm && !((l == 1 || l % 2 == 0) && d)) v = 2'b10;
    else v = 2'b00;
    if (m == 5 || m == 6 || (m == 7 && (r == 0 || r == 2 || r == 3))) w = 1;
    else if (m == 7 && r == 1) w = 2;
    else if (imm) w = (l <= 2) ? 1 : l / 2;
    else w = 0;
    vq.push_back({v, 8'(2 * w)});
    tagq.push_back(tag);
    if (v == 2'b00) begin
      left = l;
      if (left == 0) cq.push_back({3'd0, 1'b1});
      while (left > 0) begin
        int s;
        s = (left >= 4) ? 4 : (left >= 2) ? 2 : 1;
        left -= s;
        cq.push_back({3'(s), left == 0});
      end
    end
  endtask

  task automatic drive(logic [2:0] c, logic d, logic [7:0] l, logic [2:0] m, logic [2:0] r);
    @(negedge clk);
    valid_ea = c; to_cop = d; op_len = l; ea_mode = m; ea_reg = r; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic issue(logic [2:0] c, logic d, logic [7:0] l, logic [2:0] m, logic [2:0] r, string tag);
    push_model(c, d, l, m, r, tag);
    drive(c, d, l, m, r);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    if (verdict_vld) begin
      if (vq.size() == 0) chk(0, "R8 unexpected verdict", verdict, -1);
      else begin
        logic [9:0] e; string t;
        e = vq.pop_front(); t = tagq.pop_front();
        chk(verdict == e[9:8], t, verdict, e[9:8]);
        if (e[9:8] == 2'b00) chk(scan_inc == e[7:0], {t, " R6 scan"}, scan_inc, e[7:0]);
      end
    end
    if (xfer_vld || xfer_done) begin
      if (cq.size() == 0) chk(0, "R10 unexpected transfer", xfer_size, -1);
      else begin
        logic [3:0] e;
        e = cq.pop_front();
        if (e[3:1] == 0) chk(!xfer_vld && xfer_done, "R7 empty done", xfer_vld, 0);
        else chk(xfer_vld && xfer_size == e[3:1] && xfer_done == e[0], "R7 chunk",
                 {xfer_size, xfer_done}, e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !verdict_vld && !xfer_vld && !xfer_done, "R9 reset", busy, 0);
    rst_n = 1;
    issue(3'b111, 0, 4, 0, 0, "R5 Dn any");
    issue(3'b100, 1, 4, 0, 0, "R1 Dn not control");
    issue(3'b101, 0, 2, 7, 2, "R2 write pcrel");
    issue(3'b000, 0, 2, 7, 2, "R1 abort beats write");
    issue(3'b011, 0, 3, 1, 0, "R3 An len3");
    issue(3'b011, 0, 2, 1, 0, "R3 An len2");
    issue(3'b111, 1, 3, 0, 0, "R3 Dn len3");
    issue(3'b110, 1, 3, 7, 4, "R4 imm odd");
    issue(3'b110, 1, 6, 7, 4, "R4 imm six");
    issue(3'b101, 1, 1, 7, 4, "R4 imm one");
    issue(3'b111, 0, 8, 7, 4, "R4 imm write");
    issue(3'b010, 0, 255, 7, 1, "R5 absL 255");
    issue(3'b100, 1, 4, 3, 0, "R1 postinc not control");
    issue(3'b001, 0, 7, 4, 0, "R5 predec 7");
    issue(3'b000, 0, 0, 6, 0, "R7 idx len0");
    issue(3'b111, 1, 4, 7, 6, "R1 bad mode");
    issue(3'b100, 1, 5, 7, 0, "R6 absW 5");
    // R8: second start while busy must be ignored
    push_model(3'b111, 0, 16, 2, 0, "R8 long");
    drive(3'b111, 0, 16, 2, 0);
    chk(busy, "R8 busy", busy, 1);
    drive(3'b100, 1, 4, 0, 0);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(vq.size() == 0 && cq.size() == 0, "R7 queues drained", vq.size() + cq.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule